// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block serves one CPU interface of an interrupt controller. It scans every interrupt source at once. Each source presents an enable bit, a pending bit, a group bit, an 8-bit priority and a CPU target mask. The block finds the most urgent source that is allowed to reach this CPU. It then decides whether that source is visible behind the priority mask. Finally it decides whether the CPU must be interrupted now, given the running priority and the group enables.

The winner's ID appears on a status output, or the spurious value 1023 when nothing qualifies. A group 0 winner can be steered onto the fast interrupt line; everything else uses the normal interrupt line. The scan is a combinational balanced reduction tree, and all three outputs are registered. The block has no register decode, no acknowledge or completion sequencing, and no banked views. Those belong to the surrounding controller, which feeds this block the current state as plain vectors.

Top module: `prisel_top`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the cycle after it, the outputs are irq_o=0, fiq_o=0 and pend_id_o=1023, whatever the source state.
- R2: Among the candidates, the one with the numerically smallest priority value wins.
- R3: When candidates tie on priority, the one with the lower source ID wins.
- R4: A source is a candidate only if both its enable bit and its pending bit are set. An enabled source that is not pending is ignored, and so is a pending source that is not enabled.
- R5: A shared source (ID 32 or above) is a candidate only if bit CPU_ID of its target field is set. A private source (ID below 32) ignores its target field. Source i's target field is src_tgt_i[i*NUM_CPU +: NUM_CPU].
- R6: With no candidate, pend_id_o is 1023 and both lines are low.
- R7: If both distributor group enables are clear, or both CPU-interface group enables are clear, both lines are low and pend_id_o is 1023.
- R8: The winner's ID is reported only if its priority is strictly below prio_mask_i. Otherwise pend_id_o is 1023 and both lines are low.
- R9: A reported winner raises a line only if its priority is strictly below run_prio_i, a 9-bit value where 256 means idle. Otherwise the ID is still reported.
- R10: A reported winner raises a line only if its group is enabled in both dist_grp_en_i and cpu_grp_en_i. Bit 0 of each enables group 0 and bit 1 enables group 1. Otherwise the ID is still reported.
- R11: A signalled winner of group 0 drives fiq_o when fiq_en_i=1. In every other case it drives irq_o. The two lines are never high together.
- R12: The outputs are registered. A change of inputs made between clock edges shows on the outputs after the next rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | NUM_SRC | Per-source enable |
| src_pend_i | input | NUM_SRC | Per-source pending |
| src_grp_i | input | NUM_SRC | Per-source group (0 or 1) |
| src_prio_i | input | NUM_SRC*8 | Per-source priority, source i at [i*8 +: 8] |
| src_tgt_i | input | NUM_SRC*NUM_CPU | Per-source CPU target mask, source i at [i*NUM_CPU +: NUM_CPU] |
| dist_grp_en_i | input | 2 | Distributor group enables, bit g for group g |
| cpu_grp_en_i | input | 2 | CPU-interface group enables, bit g for group g |
| prio_mask_i | input | 8 | Priority mask, strict threshold |
| run_prio_i | input | 9 | Running priority, 256 = idle |
| fiq_en_i | input | 1 | Steer group 0 onto fiq_o |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |
| pend_id_o | output | 10 | Highest pending ID or 1023 |

## Verification
The bench builds the block with NUM_SRC=40, NUM_CPU=4 and CPU_ID=1. The 40 sources make the tree pad to 64 leaves, so the padding leaves take part in the tie and empty-slot handling. They also give eight shared sources above the private range, which brings the target-mask filter within reach. The bench gives shared sources a target mask that either names CPU 1 or names every other CPU, so a mismatched target bit is detected. Source 39, the last real leaf, is tested alone to cover the edge of the padded tree.

// File: rtl/prisel_pkg.sv
package prisel_pkg;
  localparam int ID_W        = 10;
  localparam int PRIO_W      = 8;
  localparam int RUNP_W      = PRIO_W + 1;
  localparam int PRIVATE_CNT = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef struct packed {
    logic              vld;
    logic              grp;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;

  // lo always carries the lower IDs, so a tie keeps lo.
  function automatic cand_t pick_better(cand_t lo, cand_t hi);
    if (lo.vld && (!hi.vld || lo.prio <= hi.prio)) return lo;
    return hi;
  endfunction
endpackage

// File: rtl/prisel_filter.sv
module prisel_filter
  import prisel_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 8,
  parameter int CPU_ID  = 0
) (
  input  logic [NUM_SRC-1:0]         src_en_i,
  input  logic [NUM_SRC-1:0]         src_pend_i,
  input  logic [NUM_SRC-1:0]         src_grp_i,
  input  logic [NUM_SRC*PRIO_W-1:0]  src_prio_i,
  input  logic [NUM_SRC*NUM_CPU-1:0] src_tgt_i,
  output cand_t                      cand_o [NUM_SRC]
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic reach;
    if (i < PRIVATE_CNT) begin : g_priv
      logic unused_tgt;
      assign unused_tgt = ^src_tgt_i[i*NUM_CPU +: NUM_CPU];
      assign reach = 1'b1;
    end else begin : g_shared
      assign reach = src_tgt_i[i*NUM_CPU + CPU_ID];
    end
    assign cand_o[i].vld  = src_en_i[i] & src_pend_i[i] & reach;
    assign cand_o[i].grp  = src_grp_i[i];
    assign cand_o[i].prio = src_prio_i[i*PRIO_W +: PRIO_W];
    assign cand_o[i].id   = ID_W'(i);
  end
endmodule

// File: rtl/prisel_tree.sv
module prisel_tree
  import prisel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  cand_t leaf_i [NUM_SRC],
  output cand_t best_o
);
  localparam int LVLS   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int LEAVES = 1 << LVLS;

  for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
    localparam int W = LEAVES >> lv;
    cand_t stg [W];
    if (lv == 0) begin : g_leaf
      for (genvar k = 0; k < W; k++) begin : g_k
        if (k < NUM_SRC) begin : g_real
          assign stg[k] = leaf_i[k];
        end else begin : g_pad
          assign stg[k] = '0;
        end
      end
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        assign stg[k] = pick_better(g_lvl[lv-1].stg[2*k], g_lvl[lv-1].stg[2*k+1]);
      end
    end
  end

  assign best_o = g_lvl[LVLS].stg[0];
endmodule

// File: rtl/prisel_out.sv
module prisel_out
  import prisel_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  cand_t             best_i,
  input  logic [1:0]        dist_grp_en_i,
  input  logic [1:0]        cpu_grp_en_i,
  input  logic [PRIO_W-1:0] prio_mask_i,
  input  logic [RUNP_W-1:0] run_prio_i,
  input  logic              fiq_en_i,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [ID_W-1:0]   pend_id_o
);
  logic            gate_open, visible, preempts, grp_ok, sig;
  logic            irq_d, fiq_d;
  logic [ID_W-1:0] id_d;

  always_comb begin
    gate_open = (|dist_grp_en_i) && (|cpu_grp_en_i);
    visible   = gate_open && best_i.vld && (best_i.prio < prio_mask_i);
    preempts  = {1'b0, best_i.prio} < run_prio_i;
    grp_ok    = dist_grp_en_i[best_i.grp] && cpu_grp_en_i[best_i.grp];
    sig       = visible && preempts && grp_ok;
    id_d      = visible ? best_i.id : SPURIOUS_ID;
    fiq_d     = sig && !best_i.grp && fiq_en_i;
    irq_d     = sig && !fiq_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      pend_id_o <= SPURIOUS_ID;
    end else begin
      irq_o     <= irq_d;
      fiq_o     <= fiq_d;
      pend_id_o <= id_d;
    end
  end

  // R11: never both lines at once
  a_r11_lines_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({irq_o, fiq_o}) <= 1);

  // R11: fast line needs the steering bit one cycle earlier
  a_r11_fiq_needs_enable: assert property (@(posedge clk) disable iff (rst)
    !fiq_en_i |=> !fiq_o);

  // R7: closed gates silence everything on the next cycle
  a_r7_gate_closed: assert property (@(posedge clk) disable iff (rst)
    (!(|dist_grp_en_i) || !(|cpu_grp_en_i)) |=>
      (!irq_o && !fiq_o && pend_id_o == SPURIOUS_ID));

  // R8: a zero mask hides every source
  a_r8_zero_mask: assert property (@(posedge clk) disable iff (rst)
    (prio_mask_i == '0) |=> (pend_id_o == SPURIOUS_ID));

  // R6: a signalled line always comes with a real ID
  a_r6_line_has_id: assert property (@(posedge clk) disable iff (rst)
    (irq_o || fiq_o) |-> (pend_id_o != SPURIOUS_ID && pend_id_o < ID_W'(NUM_SRC)));

  // R9: an idle-free running priority of zero blocks all lines
  a_r9_run_zero: assert property (@(posedge clk) disable iff (rst)
    (run_prio_i == '0) |=> (!irq_o && !fiq_o));
endmodule

// File: rtl/prisel_top.sv
module prisel_top
  import prisel_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_CPU = 8,
  parameter int CPU_ID  = 0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         src_en_i,
  input  logic [NUM_SRC-1:0]         src_pend_i,
  input  logic [NUM_SRC-1:0]         src_grp_i,
  input  logic [NUM_SRC*8-1:0]       src_prio_i,
  input  logic [NUM_SRC*NUM_CPU-1:0] src_tgt_i,
  input  logic [1:0]                 dist_grp_en_i,
  input  logic [1:0]                 cpu_grp_en_i,
  input  logic [7:0]                 prio_mask_i,
  input  logic [8:0]                 run_prio_i,
  input  logic                       fiq_en_i,
  output logic                       irq_o,
  output logic                       fiq_o,
  output logic [9:0]                 pend_id_o
);
  cand_t leaf [NUM_SRC];
  cand_t best;

  prisel_filter #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_ID(CPU_ID)) u_filter (
    .src_en_i   (src_en_i),
    .src_pend_i (src_pend_i),
    .src_grp_i  (src_grp_i),
    .src_prio_i (src_prio_i),
    .src_tgt_i  (src_tgt_i),
    .cand_o     (leaf)
  );

  prisel_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .leaf_i (leaf),
    .best_o (best)
  );

  prisel_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk           (clk),
    .rst           (rst),
    .best_i        (best),
    .dist_grp_en_i (dist_grp_en_i),
    .cpu_grp_en_i  (cpu_grp_en_i),
    .prio_mask_i   (prio_mask_i),
    .run_prio_i    (run_prio_i),
    .fiq_en_i      (fiq_en_i),
    .irq_o         (irq_o),
    .fiq_o         (fiq_o),
    .pend_id_o     (pend_id_o)
  );

  // R5: tree winner is always a real source
  a_r5_winner_in_range: assert property (@(posedge clk) disable iff (rst)
    best.vld |-> (best.id < 10'(NUM_SRC)));
endmodule

// File: tb/test_prisel_top.sv
module test_prisel_top;
  localparam int NS = 40;
  localparam int NC = 4;
  localparam int ME = 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NS-1:0]   en, pd, grp;
  logic [NS*8-1:0] prio;
  logic [NS*NC-1:0] tgt;
  logic [1:0]      den, cen;
  logic [7:0]      pm;
  logic [8:0]      rp;
  logic            fe;
  logic            irq, fiq;
  logic [9:0]      pid;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  prisel_top #(.NUM_SRC(NS), .NUM_CPU(NC), .CPU_ID(ME)) i_prisel_top (
    .clk(clk), .rst(rst), .src_en_i(en), .src_pend_i(pd), .src_grp_i(grp),
    .src_prio_i(prio), .src_tgt_i(tgt), .dist_grp_en_i(den), .cpu_grp_en_i(cen),
    .prio_mask_i(pm), .run_prio_i(rp), .fiq_en_i(fe),
    .irq_o(irq), .fiq_o(fiq), .pend_id_o(pid));

  typedef struct packed {
    logic [5:0] aid; logic [7:0] ap; logic ag, at, aen, apd;
    logic [5:0] bid; logic [7:0] bp; logic bg, bt, ben, bpd;
    logic [1:0] den, cen; logic [7:0] pm; logic [8:0] rp; logic fe;
    logic [9:0] eid; logic ei, ef; logic [3:0] req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    // R2: smaller value wins
    '{6'd5, 8'd40,1'b1,1'b1,1'b1,1'b1, 6'd9, 8'd20,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd9,   1'b1,1'b0,4'd2},
    '{6'd33,8'd10,1'b1,1'b1,1'b1,1'b1, 6'd2, 8'd11,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd33,  1'b1,1'b0,4'd2},
    // R3: ties go to the lower ID
    '{6'd7, 8'd30,1'b1,1'b1,1'b1,1'b1, 6'd3, 8'd30,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd3,   1'b1,1'b0,4'd3},
    '{6'd34,8'd50,1'b1,1'b1,1'b1,1'b1, 6'd36,8'd50,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd34,  1'b1,1'b0,4'd3},
    // R4: enable and pending both needed
    '{6'd6, 8'd5, 1'b1,1'b1,1'b1,1'b0, 6'd8, 8'd60,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd8,   1'b1,1'b0,4'd4},
    '{6'd6, 8'd5, 1'b1,1'b1,1'b0,1'b1, 6'd8, 8'd60,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd8,   1'b1,1'b0,4'd4},
    // R5: shared needs target bit, private ignores it
    '{6'd35,8'd5, 1'b1,1'b0,1'b1,1'b1, 6'd10,8'd60,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd10,  1'b1,1'b0,4'd5},
    '{6'd12,8'd5, 1'b1,1'b0,1'b1,1'b1, 6'd10,8'd60,1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd12,  1'b1,1'b0,4'd5},
    // R6: nothing qualifies
    '{6'd5, 8'd40,1'b1,1'b1,1'b0,1'b0, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd1023,1'b0,1'b0,4'd6},
    // R7: global gates
    '{6'd5, 8'd10,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd3,8'hFF,9'h100,1'b0, 10'd1023,1'b0,1'b0,4'd7},
    '{6'd5, 8'd10,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd0,8'hFF,9'h100,1'b0, 10'd1023,1'b0,1'b0,4'd7},
    // R8: strict mask threshold
    '{6'd5, 8'h40,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'h40,9'h100,1'b0, 10'd1023,1'b0,1'b0,4'd8},
    '{6'd5, 8'h40,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'h41,9'h100,1'b0, 10'd5,   1'b1,1'b0,4'd8},
    // R9: strict running-priority threshold
    '{6'd5, 8'h40,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h040,1'b0, 10'd5,   1'b0,1'b0,4'd9},
    '{6'd5, 8'h40,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h041,1'b0, 10'd5,   1'b1,1'b0,4'd9},
    // R10: winner's group must be enabled on both sides
    '{6'd5, 8'd10,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd1,2'd3,8'hFF,9'h100,1'b0, 10'd5,   1'b0,1'b0,4'd10},
    '{6'd5, 8'd10,1'b0,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd2,8'hFF,9'h100,1'b0, 10'd5,   1'b0,1'b0,4'd10},
    '{6'd5, 8'd10,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd1,8'hFF,9'h100,1'b0, 10'd5,   1'b0,1'b0,4'd10},
    // R11: line steering
    '{6'd5, 8'd10,1'b0,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h100,1'b0, 10'd5,   1'b1,1'b0,4'd11},
    '{6'd5, 8'd10,1'b0,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h100,1'b1, 10'd5,   1'b0,1'b1,4'd11},
    '{6'd5, 8'd10,1'b1,1'b1,1'b1,1'b1, 6'd0, 8'd0, 1'b0,1'b0,1'b0,1'b0, 2'd3,2'd3,8'hFF,9'h100,1'b1, 10'd5,   1'b1,1'b0,4'd11},
    '{6'd5, 8'd10,1'b0,1'b1,1'b1,1'b1, 6'd20,8'd5, 1'b1,1'b1,1'b1,1'b1, 2'd3,2'd3,8'hFF,9'h100,1'b1, 10'd20,  1'b1,1'b0,4'd11}
  };

  task automatic set_src(input int id, input logic [7:0] p, input logic g,
                         input logic t, input logic e, input logic q);
    en[id] = e;
    pd[id] = q;
    grp[id] = g;
    prio[id*8 +: 8] = p;
    tgt[id*NC +: NC] = t ? 4'b0010 : 4'b1101;
  endtask

  task automatic apply(input vec_t v);
    en = '0; pd = '0; grp = '0; prio = '1; tgt = '0;
    set_src(int'(v.aid), v.ap, v.ag, v.at, v.aen, v.apd);
    if (v.ben || v.bpd) set_src(int'(v.bid), v.bp, v.bg, v.bt, v.ben, v.bpd);
    den = v.den; cen = v.cen; pm = v.pm; rp = v.rp; fe = v.fe;
  endtask

  task automatic chk(input string req, input logic [9:0] eid, input logic ei, input logic ef);
    compared++;
    if (pid !== eid || irq !== ei || fiq !== ef) begin
      mismatched++;
      $display("FAIL %s: actual id=%0d irq=%b fiq=%b expected id=%0d irq=%b fiq=%b",
               req, pid, irq, fiq, eid, ei, ef);
    end
  endtask

  function automatic vec_t one(input logic [5:0] id, input logic [7:0] p, input logic g,
                               input logic [7:0] m, input logic [8:0] r);
    vec_t v = '0;
    v.aid = id; v.ap = p; v.ag = g; v.at = 1'b1; v.aen = 1'b1; v.apd = 1'b1;
    v.den = 2'd3; v.cen = 2'd3; v.pm = m; v.rp = r; v.fe = 1'b0;
    return v;
  endfunction

  initial begin
    apply(one(6'd4, 8'd1, 1'b1, 8'hFF, 9'h100));
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1: reset holds outputs although a candidate is present
    chk("R1", 10'd1023, 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    // R1: first edge after release still shows nothing new... it is the first sample
    // of the live state, so it reports the candidate (registered one cycle later)
    chk("R1", 10'd4, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eid, VECS[i].ei, VECS[i].ef);
    end

    // R8: last real leaf of the padded tree, priority one below the mask
    apply(one(6'd39, 8'hFE, 1'b1, 8'hFF, 9'h100));
    @(posedge clk); @(negedge clk);
    chk("R8 top source", 10'd39, 1'b1, 1'b0);

    // R9: running priority zero blocks the line, ID still shown
    apply(one(6'd39, 8'h00, 1'b1, 8'hFF, 9'h000));
    @(posedge clk); @(negedge clk);
    chk("R9 run zero", 10'd39, 1'b0, 1'b0);

    // R12: change between edges is not visible before the next rising edge
    apply(one(6'd17, 8'd3, 1'b1, 8'hFF, 9'h100));
    #5;
    chk("R12 before edge", 10'd39, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R12 after edge", 10'd17, 1'b1, 1'b0);

    // R1: reset again mid-run clears outputs
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1 re-reset", 10'd1023, 1'b0, 1'b0);
    rst = 1'b0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog R12: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule